// File: doc/BRIEF.md
# Partitioned Pixel-by-Coefficient Multiplier

This block is a SIMD multiply unit for pixel processing. Each lane multiplies an unsigned 8-bit pixel component by a signed 16-bit coefficient. It keeps the middle sixteen bits of the product and rounds them half-up. A 9-bit operation code picks one of seven variants. The variants differ in three ways: which bytes of the first operand feed the lanes, whether every lane gets its own coefficient or all lanes share one, and where the lane results are placed in the 64-bit result.

A caller presents both operands and the code together with an input-valid strobe. One clock later the packed result appears on a registered output with its own valid flag. Between operations the result register keeps its last value.

Top module: `pixmul_unit`

## Requirements
- R1: Each lane result is bits 23..8 of the product (unsigned 8-bit pixel times signed 16-bit coefficient), plus one when product bit 7 is set. The increment wraps modulo 2^16 and never saturates.
- R2: Code 0x031 takes pixel i from srcA bits [8i+7:8i] and coefficient i from srcB bits [16i+15:16i], for i = 0..3. Lane i goes to result bits [16i+15:16i].
- R3: Code 0x033 uses srcB[31:16] as the coefficient in all four lanes, and code 0x035 uses srcB[15:0]. In both, the pixels and the result placement are as in R2.
- R4: Code 0x036 takes pixel i from srcA bits [16i+15:16i+8], and code 0x037 takes it from srcA bits [16i+7:16i]. In both, coefficient i and the result placement are as in R2.
- R5: Codes 0x038 (upper byte) and 0x039 (lower byte) compute two lanes, i = 0..1, with the pixel and coefficient chosen as in R4. Lane i is placed at result bits [32i+22:32i+7].
- R6: Every result bit that the selected variant does not write is zero. Any other code gives an all-zero result.
- R7: outValid is high in the cycle after a cycle with inValid high, and the result of that operation is on result at the same time.
- R8: After a cycle with inValid low, outValid is low and result keeps its previous value.
- R9: While reset is active and right after it, outValid is 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and code are valid this cycle |
| opCode | input | 9 | Variant select |
| srcA | input | 64 | Pixel operand |
| srcB | input | 64 | Coefficient operand |
| outValid | output | 1 | result holds a new value |
| result | output | 64 | Packed lane results |

## Verification
The bench targets several edge cases:
- Products whose middle bits are all ones and whose rounding bit is set, such as 1 times -1. These must wrap to zero. A saturating or widened adder would give 0xFFFF, or would let a carry leak into the next lane.
- The largest negative and largest positive coefficients against pixel 255. These expose a pixel treated as signed, or the wrong bit slice.
- The two-lane codes, filled with operands that are all ones. A wrong 7-bit offset or a lane 2/3 that is not masked leaves stray bits.
- Unknown codes, and idle cycles between operations. These catch results that are not cleared and registers that do not hold.

// File: rtl/pixmul_pkg.sv
package pixmul_pkg;

  localparam logic [8:0] OPC_BASIC    = 9'h031;
  localparam logic [8:0] OPC_ALPHA_HI = 9'h033;
  localparam logic [8:0] OPC_ALPHA_LO = 9'h035;
  localparam logic [8:0] OPC_BYTE_HI  = 9'h036;
  localparam logic [8:0] OPC_BYTE_LO  = 9'h037;
  localparam logic [8:0] OPC_PAIR_HI  = 9'h038;
  localparam logic [8:0] OPC_PAIR_LO  = 9'h039;

  // where a lane's pixel byte comes from
  typedef enum logic [1:0] {
    PIX_PACKED = 2'd0,
    PIX_UPPER  = 2'd1,
    PIX_LOWER  = 2'd2
  } pixSel_e;

  // where a lane's coefficient comes from
  typedef enum logic [1:0] {
    COEF_LANE  = 2'd0,
    COEF_UPPER = 2'd1,
    COEF_LOWER = 2'd2
  } coefSel_e;

  typedef struct packed {
    logic     load;
    logic     known;
    logic     twoLane;
    pixSel_e  pixSel;
    coefSel_e coefSel;
  } strobe_t;

endpackage

// File: rtl/pixmul_lane.sv
module pixmul_lane #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16
) (
  input  logic [PIX_W-1:0]  pix,
  input  logic [COEF_W-1:0] coef,
  output logic [COEF_W-1:0] mid
);
  localparam int PROD_W = PIX_W + COEF_W + 1;

  logic signed [PROD_W-1:0] prod;

  // pixel is zero-extended so that it multiplies as unsigned
  assign prod = $signed({1'b0, pix}) * $signed(coef);
  // keep the middle field, add the rounding bit, wrap within the field
  assign mid  = prod[PIX_W+COEF_W-1:PIX_W] + {{(COEF_W-1){1'b0}}, prod[PIX_W-1]};
endmodule

// File: rtl/pixmul_ctrl.sv
module pixmul_ctrl
  import pixmul_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [8:0] opCode,
  output strobe_t    strb,
  output logic       outValid
);

  always_comb begin
    strb         = '0;
    strb.load    = inValid;
    strb.pixSel  = PIX_PACKED;
    strb.coefSel = COEF_LANE;
    unique case (opCode)
      OPC_BASIC:    strb.known = 1'b1;
      OPC_ALPHA_HI: begin strb.known = 1'b1; strb.coefSel = COEF_UPPER; end
      OPC_ALPHA_LO: begin strb.known = 1'b1; strb.coefSel = COEF_LOWER; end
      OPC_BYTE_HI:  begin strb.known = 1'b1; strb.pixSel  = PIX_UPPER;  end
      OPC_BYTE_LO:  begin strb.known = 1'b1; strb.pixSel  = PIX_LOWER;  end
      OPC_PAIR_HI:  begin strb.known = 1'b1; strb.pixSel  = PIX_UPPER; strb.twoLane = 1'b1; end
      OPC_PAIR_LO:  begin strb.known = 1'b1; strb.pixSel  = PIX_LOWER; strb.twoLane = 1'b1; end
      default:      strb.known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R7: valid follows the input strobe by one cycle
  a_r7_valid_next: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R8: no output valid after an idle cycle
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/pixmul_dp.sv
module pixmul_dp
  import pixmul_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int COEF_W   = 16,
  parameter int LANES    = 4,
  parameter int PAIR_OFS = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [LANES*COEF_W-1:0] srcA,
  input  logic [LANES*COEF_W-1:0] srcB,
  output logic [LANES*COEF_W-1:0] result
);
  localparam int OUT_W      = LANES * COEF_W;
  localparam int PAIR_LANES = LANES / 2;
  localparam int PAIR_PITCH = 2 * COEF_W;

  logic [LANES-1:0][COEF_W-1:0] laneMid;
  logic [OUT_W-1:0]             nextResult;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [PIX_W-1:0]  pix;
    logic [COEF_W-1:0] coef;

    always_comb begin
      unique case (strb.pixSel)
        PIX_UPPER: pix = srcA[i*COEF_W+PIX_W +: PIX_W];
        PIX_LOWER: pix = srcA[i*COEF_W +: PIX_W];
        default:   pix = srcA[i*PIX_W +: PIX_W];
      endcase
      unique case (strb.coefSel)
        COEF_UPPER: coef = srcB[COEF_W +: COEF_W];
        COEF_LOWER: coef = srcB[0 +: COEF_W];
        default:    coef = srcB[i*COEF_W +: COEF_W];
      endcase
    end

    pixmul_lane #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_lane (
      .pix  (pix),
      .coef (coef),
      .mid  (laneMid[i])
    );
  end

  always_comb begin
    nextResult = '0;
    if (strb.known) begin
      if (strb.twoLane) begin
        for (int i = 0; i < PAIR_LANES; i++)
          nextResult[i*PAIR_PITCH+PAIR_OFS +: COEF_W] = laneMid[i];
      end else begin
        for (int i = 0; i < LANES; i++)
          nextResult[i*COEF_W +: COEF_W] = laneMid[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          result <= '0;
    else if (strb.load) result <= nextResult;
  end

  // R8: the result register holds across idle cycles
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(result));

endmodule

// File: rtl/pixmul_unit.sv
module pixmul_unit
  import pixmul_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int COEF_W   = 16,
  parameter int LANES    = 4,
  parameter int PAIR_OFS = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [8:0]              opCode,
  input  logic [LANES*COEF_W-1:0] srcA,
  input  logic [LANES*COEF_W-1:0] srcB,
  output logic                    outValid,
  output logic [LANES*COEF_W-1:0] result
);
  localparam int OUT_W = LANES * COEF_W;

  strobe_t strb;

  pixmul_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opCode   (opCode),
    .strb     (strb),
    .outValid (outValid)
  );

  pixmul_dp #(
    .PIX_W    (PIX_W),
    .COEF_W   (COEF_W),
    .LANES    (LANES),
    .PAIR_OFS (PAIR_OFS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (result)
  );

  function automatic logic [OUT_W-1:0] pairFieldMask();
    logic [OUT_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES / 2; i++)
      m[i*2*COEF_W+PAIR_OFS +: COEF_W] = '1;
    return m;
  endfunction

  localparam logic [OUT_W-1:0] PAIR_MASK = pairFieldMask();

  logic isPair;
  logic isKnown;
  assign isPair  = (opCode == OPC_PAIR_HI) || (opCode == OPC_PAIR_LO);
  assign isKnown = isPair || (opCode == OPC_BASIC) || (opCode == OPC_ALPHA_HI) ||
                   (opCode == OPC_ALPHA_LO) || (opCode == OPC_BYTE_HI) ||
                   (opCode == OPC_BYTE_LO);

  // R5/R6: bits outside the two placed lanes stay zero
  a_r5_pair_gaps_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isPair) |=> ((result & ~PAIR_MASK) == '0));
  // R6: unknown codes give a zero result
  a_r6_unknown_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isKnown) |=> (result == '0));

endmodule

// File: tb/test_pixmul_unit.sv
module test_pixmul_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [8:0]  opCode = '0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        outValid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        expValid = 1'b0;
  logic [63:0] expResult = '0;

  always #5 clk = ~clk;

  pixmul_unit i_pixmul_unit (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opCode   (opCode),
    .srcA     (srcA),
    .srcB     (srcB),
    .outValid (outValid),
    .result   (result)
  );

  // behavioural lane arithmetic on plain integers (R1)
  function automatic logic [15:0] midOf(input int pix, input int coef);
    int p;
    p = pix * coef;
    return 16'(((p >>> 8) + ((p >>> 7) & 1)) & 'hFFFF);
  endfunction

  function automatic logic [63:0] refCalc(input logic [8:0] op,
                                          input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    int pix;
    int coef;
    r = '0;
    case (op)
      9'h031, 9'h033, 9'h035: begin
        for (int k = 0; k < 4; k++) begin
          pix = int'(a[8*k +: 8]);
          if (op == 9'h033)      coef = int'($signed(b[31:16]));
          else if (op == 9'h035) coef = int'($signed(b[15:0]));
          else                   coef = int'($signed(b[16*k +: 16]));
          r[16*k +: 16] = midOf(pix, coef);
        end
      end
      9'h036, 9'h037: begin
        for (int k = 0; k < 4; k++) begin
          pix  = (op == 9'h036) ? int'(a[16*k+8 +: 8]) : int'(a[16*k +: 8]);
          coef = int'($signed(b[16*k +: 16]));
          r[16*k +: 16] = midOf(pix, coef);
        end
      end
      9'h038, 9'h039: begin
        for (int k = 0; k < 2; k++) begin
          pix  = (op == 9'h038) ? int'(a[16*k+8 +: 8]) : int'(a[16*k +: 8]);
          coef = int'($signed(b[16*k +: 16]));
          r = r | (64'(midOf(pix, coef)) << (32*k + 7));
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock of stimulus; model updated, outputs compared at the next falling edge
  task automatic step(input bit v, input logic [8:0] op, input logic [63:0] a,
                      input logic [63:0] b, input string req);
    inValid = v;
    opCode  = op;
    srcA    = a;
    srcB    = b;
    expValid = v;
    if (v) expResult = refCalc(op, a, b);
    @(posedge clk);
    @(negedge clk);
    check(v ? "R7" : "R8", 64'(outValid), 64'(expValid));
    check(v ? req : "R8", result, expResult);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", 64'(outValid), 64'd0);
    check("R9", result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", 64'(outValid), 64'd0);
    check("R9", result, 64'd0);

    // R1: rounding and wrap corners through the basic code
    step(1, 9'h031, 64'h0000_0000_0101_0101, 64'h0080_007F_FFFF_0001, "R1");
    step(1, 9'h031, 64'h0000_0000_FFFF_FFFF, 64'h8000_7FFF_8000_7FFF, "R1");
    step(1, 9'h031, 64'h0000_0000_0180_FF01, 64'hFF80_0100_FFFF_FFFF, "R1");
    // R2 basic
    step(1, 9'h031, 64'hDEAD_BEEF_1234_5678, 64'h1111_F00D_8001_0203, "R2");
    // R8 idle holds
    step(0, 9'h031, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    step(0, 9'h000, '0, '0, "R8");
    // R3 broadcast coefficient
    step(1, 9'h033, 64'hFFFF_FFFF_80FF_0102, 64'h5555_5555_8000_7FFF, "R3");
    step(1, 9'h035, 64'hFFFF_FFFF_80FF_0102, 64'h5555_5555_8000_7FFF, "R3");
    // R4 byte select
    step(1, 9'h036, 64'hFF01_80FF_0102_7F80, 64'h8000_FFFF_0100_1234, "R4");
    step(1, 9'h037, 64'hFF01_80FF_0102_7F80, 64'h8000_FFFF_0100_1234, "R4");
    // R5 two-lane placement, all-ones operands
    step(1, 9'h038, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
    step(1, 9'h039, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_7FFF_8000, "R5");
    step(1, 9'h038, 64'hAAAA_AAAA_FF80_7F01, 64'h1234_5678_8000_7FFF, "R5");
    // R6 unknown codes
    step(1, 9'h032, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, "R6");
    step(1, 9'h1B1, 64'h0123_4567_89AB_CDEF, 64'h7FFF_7FFF_7FFF_7FFF, "R6");

    // random mix with idle gaps, checked every clock
    for (int n = 0; n < 400; n++) begin
      logic [8:0] op;
      int sel;
      sel = int'($urandom_range(0, 8));
      case (sel)
        0: op = 9'h031;
        1: op = 9'h033;
        2: op = 9'h035;
        3: op = 9'h036;
        4: op = 9'h037;
        5: op = 9'h038;
        6: op = 9'h039;
        default: op = 9'($urandom);
      endcase
      step(($urandom_range(0, 3) != 0), op, {$urandom, $urandom}, {$urandom, $urandom},
           (sel < 3) ? "R2" : (sel < 5) ? "R4" : (sel < 7) ? "R5" : "R6");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule